// File: doc/BRIEF.md
# Hex Keypad Front-Panel Monitor

This block is the operator front panel of a small computer with an 8-bit address space. It receives already-debounced key events from a sixteen-key hexadecimal pad and a shift key. From these it keeps a current address, reads and writes memory bytes, and controls the CPU. Unshifted, every key enters a hex digit. Six keys also carry a shifted command: choose address entry, choose data entry, step to the next address, start the CPU, halt it, or run a single instruction.

Digits are collected in pairs, high nibble first. In address entry a pair becomes the current address. In data entry a pair is written to memory at the current address, and the address then moves on by one, so a program can be typed in as a continuous stream of digits. When the CPU is halted, the register contents presented by the CPU are copied into a fixed window of memory so that they can be inspected with the same keys.

The panel display is a 5x5 dot matrix that shows two bytes in binary, one nibble per row, with a blank row between the bytes. The first byte is always the current address. The second byte is either the memory byte at that address or, while a data pair is half typed, the nibble entered so far.

Top module: `hexpad_monitor`

## Requirements
- R1: After synchronous active-low reset the current address is 0x00, address entry is selected, no digit is pending, the CPU is halted (cpu_run low), no pulse is raised, and the display shows address 0x00 with the memory byte at 0x00.
- R2: With key_shift high, only codes 0x1 (next), 0x7 (data entry), 0xA (address entry), 0xC (halt), 0xE (single step) and 0xF (start) act. Any other shifted code is ignored, including a digit that is already pending.
- R3: In address entry, two unshifted digits, high nibble first, replace the current address. The new address is shown in the cycle after the second key is sampled.
- R4: In data entry, the second digit of a pair raises mem_we for one cycle, in the cycle after that key, with mem_addr equal to the old current address and mem_wdata equal to {first, second}. In that same cycle the current address becomes old+1, wrapping from 0xFF to 0x00.
- R5: The next command adds one to the current address (0xFF wraps to 0x00) and drops any pending digit.
- R6: The start command raises cpu_go for exactly one cycle, in the cycle after the key, with cpu_pc equal to the current address. cpu_run is high from that cycle until a halt command.
- R7: While cpu_run is high, mem_we and mem_re stay low and every key except the halt command is ignored, so the current address and memory are unchanged.
- R8: A halt command, whether the CPU is running or already halted, drops cpu_run in the cycle after the key. It then writes register byte i (cpu_regs[8i+7:8i]) to address DUMP_BASE+i over NREGS consecutive cycles, starting with i = 0. Keys arriving during this copy are ignored.
- R9: The single-step command raises cpu_step for exactly one cycle, in the cycle after the key, without raising cpu_run. All keys are then ignored until cpu_step_done is sampled high.
- R10: A half-entered pair is dropped by any shifted command, and nothing is written for it.
- R11: disp row r occupies bits [5r+4:5r], and bit 5r+4 is the leftmost column, which is always off. Rows 0 and 1 hold the high and low nibble of the first byte, row 2 is blank, and rows 3 and 4 hold the high and low nibble of the second byte, each with its most significant bit on the left.
- R12: The first displayed byte is the current address. The second is {pending nibble, 0x0} while in data entry with one digit pending, and otherwise mem_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | One-cycle strobe marking a key event |
| key_code | input | 4 | Hex key value, 0x0 to 0xF |
| key_shift | input | 1 | Shift key state for this event |
| cpu_regs | input | NREGS*8 | CPU register bytes, byte i at bits 8i+7:8i |
| cpu_step_done | input | 1 | CPU reports the single instruction finished |
| mem_rdata | input | 8 | Asynchronous read data for mem_addr |
| mem_addr | output | 8 | Memory address for read or write |
| mem_we | output | 1 | Memory write enable, one cycle per byte |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read request, high while the CPU is not running |
| cpu_run | output | 1 | Continuous execution enable |
| cpu_go | output | 1 | One-cycle start pulse that loads cpu_pc |
| cpu_step | output | 1 | One-cycle single-instruction pulse |
| cpu_pc | output | 8 | Start address, equal to the current address |
| disp | output | 25 | 5x5 dot pattern, row r at bits 5r+4:5r |

## Verification
Each command takes effect at the first rising edge that samples key_valid. Its outputs (address change, cpu_go, cpu_step, cpu_run, a data write) are due one cycle after that edge. A data byte reaches memory one edge later, and the register copy fills the NREGS cycles that follow a halt key. A behavioural model in the bench advances on the same edges, and every output is compared with it at each falling edge, so a result that comes one cycle early or late is flagged. Directed checks are placed after each key has settled: they look at the display, the memory contents and the pulse counts, which shows that ignored keys left the address and memory unchanged.

// File: rtl/hexpad_monitor_pkg.sv
// Package: shared widths, command encoding and run-state encoding for the
// hex keypad front-panel monitor. Assumes an 8-bit address and data path.
package hexpad_monitor_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NIB_W     = 4;
    localparam int DISP_COLS = NIB_W + 1;
    localparam int DISP_ROWS = 2 * (DATA_W / NIB_W) + 1;
    localparam int BLANK_ROW = DATA_W / NIB_W;
    localparam int DISP_W    = DISP_ROWS * DISP_COLS;

    // Shifted key codes that carry a command
    localparam logic [NIB_W-1:0] KEY_NEXT = 4'h1;
    localparam logic [NIB_W-1:0] KEY_DATA = 4'h7;
    localparam logic [NIB_W-1:0] KEY_ADDR = 4'hA;
    localparam logic [NIB_W-1:0] KEY_HALT = 4'hC;
    localparam logic [NIB_W-1:0] KEY_STEP = 4'hE;
    localparam logic [NIB_W-1:0] KEY_GO   = 4'hF;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_DIGIT,
        CMD_NEXT,
        CMD_ADDR_MODE,
        CMD_DATA_MODE,
        CMD_GO,
        CMD_HALT,
        CMD_STEP
    } cmd_e;

    typedef enum logic [1:0] {
        ST_HALTED,
        ST_RUNNING,
        ST_STEPPING,
        ST_DUMPING
    } run_e;

    typedef struct packed {
        cmd_e             op;
        logic [NIB_W-1:0] digit;
    } key_cmd_t;

endpackage

// File: rtl/hexpad_keydec.sv
// Module: hexpad_keydec
// Turns one key event (code plus shift state) into a panel command.
// Unshifted keys are digits; six shifted keys are commands; the rest map to
// no operation. Assumes key_valid is a clean one-cycle strobe.
module hexpad_keydec
    import hexpad_monitor_pkg::*;
(
    input  logic             key_valid,
    input  logic [NIB_W-1:0] key_code,
    input  logic             key_shift,
    output key_cmd_t         cmd
);

    // Purpose: map code and shift to a command
    always_comb begin
        cmd.digit = key_code;
        cmd.op    = CMD_NONE;
        if (key_valid) begin
            if (!key_shift) begin
                cmd.op = CMD_DIGIT;
            end else begin
                unique case (key_code)
                    KEY_NEXT: cmd.op = CMD_NEXT;
                    KEY_DATA: cmd.op = CMD_DATA_MODE;
                    KEY_ADDR: cmd.op = CMD_ADDR_MODE;
                    KEY_HALT: cmd.op = CMD_HALT;
                    KEY_STEP: cmd.op = CMD_STEP;
                    KEY_GO:   cmd.op = CMD_GO;
                    default:  cmd.op = CMD_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/hexpad_ctrl.sv
// Module: hexpad_ctrl
// Entry-mode and run-control state machine. Holds the current address, the
// entry mode and a pending high nibble. Issues memory writes and CPU
// start/step pulses, and copies the CPU registers into memory after a halt.
// Assumes the memory read is asynchronous and that the CPU accepts
// cpu_go/cpu_step as single-cycle pulses.
module hexpad_ctrl
    import hexpad_monitor_pkg::*;
#(
    parameter int                NREGS     = 4,
    parameter logic [ADDR_W-1:0] DUMP_BASE = 8'hF0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  key_cmd_t                  cmd,
    input  logic [NREGS*DATA_W-1:0]   cpu_regs,
    input  logic                      cpu_step_done,
    output logic [ADDR_W-1:0]         cur_addr,
    output logic                      data_mode,
    output logic                      digit_pending,
    output logic [NIB_W-1:0]          pending_nib,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_we,
    output logic [DATA_W-1:0]         mem_wdata,
    output logic                      mem_re,
    output logic                      cpu_run,
    output logic                      cpu_go,
    output logic                      cpu_step
);

    localparam int              IDX_W    = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREGS - 1);

    run_e               state;
    logic [IDX_W-1:0]   dump_idx;
    logic               wr_q;
    logic [ADDR_W-1:0]  wr_addr_q;
    logic [DATA_W-1:0]  wr_data_q;
    logic               go_q;
    logic               step_q;
    logic [DATA_W-1:0]  reg_bytes [NREGS];
    logic [ADDR_W-1:0]  next_addr;

    // Split the flat register bus into bytes
    for (genvar g = 0; g < NREGS; g++) begin : g_reg_byte
        assign reg_bytes[g] = cpu_regs[g*DATA_W +: DATA_W];
    end

    assign next_addr = cur_addr + ADDR_W'(1);

    // Purpose: entry, run-control and register-copy sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_HALTED;
            cur_addr      <= '0;
            data_mode     <= 1'b0;
            digit_pending <= 1'b0;
            pending_nib   <= '0;
            dump_idx      <= '0;
            wr_q          <= 1'b0;
            wr_addr_q     <= '0;
            wr_data_q     <= '0;
            go_q          <= 1'b0;
            step_q        <= 1'b0;
        end else begin
            wr_q   <= 1'b0;
            go_q   <= 1'b0;
            step_q <= 1'b0;
            unique case (state)
                ST_HALTED: begin
                    unique case (cmd.op)
                        CMD_DIGIT: begin
                            if (!digit_pending) begin
                                digit_pending <= 1'b1;
                                pending_nib   <= cmd.digit;
                            end else begin
                                digit_pending <= 1'b0;
                                if (data_mode) begin
                                    wr_q      <= 1'b1;
                                    wr_addr_q <= cur_addr;
                                    wr_data_q <= {pending_nib, cmd.digit};
                                    cur_addr  <= next_addr;
                                end else begin
                                    cur_addr  <= {pending_nib, cmd.digit};
                                end
                            end
                        end
                        CMD_NEXT: begin
                            digit_pending <= 1'b0;
                            cur_addr      <= next_addr;
                        end
                        CMD_ADDR_MODE: begin
                            digit_pending <= 1'b0;
                            data_mode     <= 1'b0;
                        end
                        CMD_DATA_MODE: begin
                            digit_pending <= 1'b0;
                            data_mode     <= 1'b1;
                        end
                        CMD_GO: begin
                            digit_pending <= 1'b0;
                            go_q          <= 1'b1;
                            state         <= ST_RUNNING;
                        end
                        CMD_HALT: begin
                            digit_pending <= 1'b0;
                            dump_idx      <= '0;
                            state         <= ST_DUMPING;
                        end
                        CMD_STEP: begin
                            digit_pending <= 1'b0;
                            step_q        <= 1'b1;
                            state         <= ST_STEPPING;
                        end
                        default: ;
                    endcase
                end
                ST_RUNNING: begin
                    if (cmd.op == CMD_HALT) begin
                        dump_idx <= '0;
                        state    <= ST_DUMPING;
                    end
                end
                ST_STEPPING: begin
                    if (cpu_step_done) begin
                        state <= ST_HALTED;
                    end
                end
                ST_DUMPING: begin
                    if (dump_idx == LAST_IDX) begin
                        state <= ST_HALTED;
                    end else begin
                        dump_idx <= dump_idx + IDX_W'(1);
                    end
                end
                default: state <= ST_HALTED;
            endcase
        end
    end

    // Purpose: select the memory access for this cycle
    always_comb begin
        if (state == ST_DUMPING) begin
            mem_we    = 1'b1;
            mem_addr  = DUMP_BASE + ADDR_W'(dump_idx);
            mem_wdata = reg_bytes[dump_idx];
        end else begin
            mem_we    = wr_q;
            mem_addr  = wr_q ? wr_addr_q : cur_addr;
            mem_wdata = wr_data_q;
        end
    end

    assign mem_re   = (state != ST_RUNNING);
    assign cpu_run  = (state == ST_RUNNING);
    assign cpu_go   = go_q;
    assign cpu_step = step_q;

endmodule

// File: rtl/hexpad_display.sv
// Module: hexpad_display
// Builds the 5x5 dot pattern: two bytes as binary nibbles, one per row,
// MSB on the left, a blank row between the bytes and an unlit leading column.
// Purely combinational; assumes row r occupies bits [5r+4:5r].
module hexpad_display
    import hexpad_monitor_pkg::*;
(
    input  logic [DATA_W-1:0] first_byte,
    input  logic [DATA_W-1:0] second_byte,
    output logic [DISP_W-1:0] disp
);

    localparam int NIBS = DATA_W / NIB_W;

    // Purpose: place one nibble (or nothing) in each row
    for (genvar r = 0; r < DISP_ROWS; r++) begin : g_row
        if (r == BLANK_ROW) begin : g_blank
            assign disp[r*DISP_COLS +: DISP_COLS] = '0;
        end else begin : g_nib
            localparam int  POS    = (r > BLANK_ROW) ? (r - BLANK_ROW - 1) : r;
            localparam int  SHIFT  = (NIBS - 1 - POS) * NIB_W;
            localparam bit  SECOND = (r > BLANK_ROW);
            logic [DATA_W-1:0] src;
            assign src = SECOND ? second_byte : first_byte;
            assign disp[r*DISP_COLS +: DISP_COLS] = {1'b0, src[SHIFT +: NIB_W]};
        end
    end

endmodule

// File: rtl/hexpad_monitor.sv
// Module: hexpad_monitor (top)
// Hex keypad front-panel monitor: key decode, entry/run control and the
// 5x5 display pattern. Assumes an external asynchronous-read memory and
// debounced one-cycle key strobes.
module hexpad_monitor
    import hexpad_monitor_pkg::*;
#(
    parameter int                NREGS     = 4,
    parameter logic [ADDR_W-1:0] DUMP_BASE = 8'hF0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    key_valid,
    input  logic [NIB_W-1:0]        key_code,
    input  logic                    key_shift,
    input  logic [NREGS*DATA_W-1:0] cpu_regs,
    input  logic                    cpu_step_done,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_we,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    mem_re,
    output logic                    cpu_run,
    output logic                    cpu_go,
    output logic                    cpu_step,
    output logic [ADDR_W-1:0]       cpu_pc,
    output logic [DISP_W-1:0]       disp
);

    key_cmd_t          cmd;
    logic [ADDR_W-1:0] cur_addr;
    logic              data_mode;
    logic              digit_pending;
    logic [NIB_W-1:0]  pending_nib;
    logic [DATA_W-1:0] second_byte;

    hexpad_keydec u_keydec (
        .key_valid (key_valid),
        .key_code  (key_code),
        .key_shift (key_shift),
        .cmd       (cmd)
    );

    hexpad_ctrl #(
        .NREGS     (NREGS),
        .DUMP_BASE (DUMP_BASE)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd           (cmd),
        .cpu_regs      (cpu_regs),
        .cpu_step_done (cpu_step_done),
        .cur_addr      (cur_addr),
        .data_mode     (data_mode),
        .digit_pending (digit_pending),
        .pending_nib   (pending_nib),
        .mem_addr      (mem_addr),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_re        (mem_re),
        .cpu_run       (cpu_run),
        .cpu_go        (cpu_go),
        .cpu_step      (cpu_step)
    );

    // Purpose: pick the second displayed byte
    always_comb begin
        if (data_mode && digit_pending) begin
            second_byte = {pending_nib, {NIB_W{1'b0}}};
        end else begin
            second_byte = mem_rdata;
        end
    end

    hexpad_display u_display (
        .first_byte  (cur_addr),
        .second_byte (second_byte),
        .disp        (disp)
    );

    assign cpu_pc = cur_addr;

endmodule

// File: rtl/hexpad_monitor_checker.sv
// Module: hexpad_monitor_checker
// Protocol checks on the monitor's CPU and memory ports, bound to the top.
module hexpad_monitor_checker
    import hexpad_monitor_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DUMP_BASE = 8'hF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_run,
    input logic              cpu_go,
    input logic              cpu_step,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1: the first cycle after reset leaves the CPU halted
    assert_halted_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !cpu_run);

    // R6: start pulse lasts one cycle and coincides with run
    assert_go_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_go |=> !cpu_go);
    assert_go_with_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_go |-> cpu_run);

    // R7: no memory traffic while running
    assert_quiet_memory_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> (!mem_we && !mem_re));

    // R8: halting from run starts the register copy at the window base
    assert_copy_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_run) |-> (mem_we && mem_addr == DUMP_BASE));

    // R9: step pulse lasts one cycle and never while running
    assert_step_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_step |=> !cpu_step);
    assert_step_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_step |-> !cpu_run);

endmodule

bind hexpad_monitor hexpad_monitor_checker #(
    .DUMP_BASE (DUMP_BASE)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_run  (cpu_run),
    .cpu_go   (cpu_go),
    .cpu_step (cpu_step),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr)
);

// File: tb/hexpad_monitor_tb.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed scenarios for each requirement.
module hexpad_monitor_tb;

    localparam int         NREGS     = 4;
    localparam logic [7:0] DUMP_BASE = 8'hF0;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 key_valid = 1'b0;
    logic [3:0]           key_code = 4'h0;
    logic                 key_shift = 1'b0;
    logic [NREGS*8-1:0]   cpu_regs = 32'hC3A51E77;
    logic                 cpu_step_done = 1'b0;
    logic [7:0]           mem_rdata;
    logic [7:0]           mem_addr;
    logic                 mem_we;
    logic [7:0]           mem_wdata;
    logic                 mem_re;
    logic                 cpu_run;
    logic                 cpu_go;
    logic                 cpu_step;
    logic [7:0]           cpu_pc;
    logic [24:0]          disp;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hexpad_monitor #(.NREGS(NREGS), .DUMP_BASE(DUMP_BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .key_shift(key_shift), .cpu_regs(cpu_regs), .cpu_step_done(cpu_step_done),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .cpu_run(cpu_run),
        .cpu_go(cpu_go), .cpu_step(cpu_step), .cpu_pc(cpu_pc), .disp(disp)
    );

    // Memory attached to the block
    logic [7:0] ram [256];
    initial for (int i = 0; i < 256; i++) ram[i] = 8'(i) ^ 8'h5A;
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;
    assign mem_rdata = ram[mem_addr];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [24:0] fdisp(input logic [7:0] a, input logic [7:0] b);
        logic [24:0] d = '0;
        d[4:0]   = {1'b0, a[7:4]};
        d[9:5]   = {1'b0, a[3:0]};
        d[19:15] = {1'b0, b[7:4]};
        d[24:20] = {1'b0, b[3:0]};
        return d;
    endfunction

    // Reference model: 0 halted, 1 running, 2 stepping, 3 copying registers
    int         m_st;
    int         m_di;
    logic       m_dm, m_half, m_we, m_go, m_step;
    logic [3:0] m_hi;
    logic [7:0] m_addr, m_wa, m_wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_di <= 0; m_dm <= 0; m_half <= 0; m_hi <= 0;
            m_addr <= 0; m_wa <= 0; m_wd <= 0; m_we <= 0; m_go <= 0; m_step <= 0;
        end else begin
            m_we <= 0; m_go <= 0; m_step <= 0;
            if (m_st == 0 && key_valid) begin
                if (!key_shift) begin
                    if (!m_half) begin
                        m_half <= 1; m_hi <= key_code;
                    end else begin
                        m_half <= 0;
                        if (m_dm) begin
                            m_we <= 1; m_wa <= m_addr; m_wd <= {m_hi, key_code};
                            m_addr <= m_addr + 8'd1;
                        end else begin
                            m_addr <= {m_hi, key_code};
                        end
                    end
                end else begin
                    case (key_code)
                        4'h1: begin m_half <= 0; m_addr <= m_addr + 8'd1; end
                        4'h7: begin m_half <= 0; m_dm <= 1; end
                        4'hA: begin m_half <= 0; m_dm <= 0; end
                        4'hF: begin m_half <= 0; m_go <= 1; m_st <= 1; end
                        4'hC: begin m_half <= 0; m_di <= 0; m_st <= 3; end
                        4'hE: begin m_half <= 0; m_step <= 1; m_st <= 2; end
                        default: ;
                    endcase
                end
            end else if (m_st == 1) begin
                if (key_valid && key_shift && key_code == 4'hC) begin
                    m_di <= 0; m_st <= 3;
                end
            end else if (m_st == 2) begin
                if (cpu_step_done) m_st <= 0;
            end else if (m_st == 3) begin
                if (m_di == NREGS - 1) m_st <= 0;
                else m_di <= m_di + 1;
            end
        end
    end

    logic [7:0] e_addr, e_wd, e_second;
    logic       e_we;
    assign e_we     = m_we || (m_st == 3);
    assign e_addr   = (m_st == 3) ? DUMP_BASE + 8'(m_di) : (m_we ? m_wa : m_addr);
    assign e_wd     = (m_st == 3) ? cpu_regs[m_di*8 +: 8] : m_wd;
    assign e_second = (m_dm && m_half) ? {m_hi, 4'h0} : ram[e_addr];

    // Per-cycle comparison with the model, away from the active edge
    int go_cnt = 0, step_cnt = 0;
    logic [7:0] go_pc = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6 cpu_run", cpu_run, m_st == 1);
            chk("R6 cpu_go", cpu_go, m_go);
            chk("R9 cpu_step", cpu_step, m_step);
            chk("R7 mem_re", mem_re, m_st != 1);
            chk(m_st == 3 ? "R8 mem_we" : "R4 mem_we", mem_we, e_we);
            if (e_we) begin
                chk(m_st == 3 ? "R8 mem_addr" : "R4 mem_addr", mem_addr, e_addr);
                chk(m_st == 3 ? "R8 mem_wdata" : "R4 mem_wdata", mem_wdata, e_wd);
            end
            chk("R11 disp", disp, fdisp(m_addr, e_second));
            if (cpu_go) begin go_cnt++; go_pc = cpu_pc; end
            if (cpu_step) step_cnt++;
        end
    end

    task automatic press(input logic sh, input logic [3:0] c);
        @(negedge clk); key_valid = 1; key_shift = sh; key_code = c;
        @(negedge clk); key_valid = 0; key_shift = 0; key_code = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    logic [7:0] saved;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cpu_run", cpu_run, 0);
        chk("R1 pulses", {cpu_go, cpu_step, mem_we}, 0);
        chk("R1 disp", disp, fdisp(8'h00, ram[0]));

        // R3 address entry
        press(1, 4'hA); press(0, 4'h3); press(0, 4'hC);
        chk("R3 addr 3C", disp, fdisp(8'h3C, ram[8'h3C]));
        // R5 next and wrap
        press(1, 4'h1);
        chk("R5 next 3D", disp, fdisp(8'h3D, ram[8'h3D]));
        press(0, 4'hF); press(0, 4'hF); press(1, 4'h1);
        chk("R5 wrap", disp, fdisp(8'h00, ram[8'h00]));
        // R11 frame layout
        chk("R11 blanks", {disp[24], disp[19], disp[14:10], disp[9], disp[4]}, 0);
        // R2 unmapped shifted keys ignored, pending digit kept
        press(0, 4'h8); press(1, 4'h3); press(1, 4'h5); press(0, 4'h1);
        chk("R2 ignored shift", disp, fdisp(8'h81, ram[8'h81]));

        // R12 / R4 data entry
        press(1, 4'hA); press(0, 4'h1); press(0, 4'h0);
        press(1, 4'h7); press(0, 4'h4);
        chk("R12 pending", disp, fdisp(8'h10, 8'h40));
        press(0, 4'hB);
        chk("R4 written", ram[8'h10], 8'h4B);
        chk("R4 advanced", disp, fdisp(8'h11, ram[8'h11]));

        // R10 half pair dropped
        saved = ram[8'h11];
        press(0, 4'h9); press(1, 4'hA);
        chk("R10 no write", ram[8'h11], saved);
        press(1, 4'h7); press(0, 4'h2); press(0, 4'h6);
        chk("R10 fresh pair", ram[8'h11], 8'h26);

        // R6 go
        saved = ram[8'h12];
        press(1, 4'hF);
        chk("R6 running", cpu_run, 1);
        chk("R6 one go", go_cnt, 1);
        chk("R6 go pc", go_pc, 8'h12);
        // R7 keys ignored while running
        press(0, 4'h5); press(0, 4'h5); press(1, 4'h1); press(1, 4'hA);
        chk("R7 still running", cpu_run, 1);
        chk("R7 addr kept", disp[9:0], fdisp(8'h12, 8'h00) & 25'h3FF);
        chk("R7 mem kept", ram[8'h12], saved);

        // R8 halt and register copy, key during copy ignored
        press(1, 4'hC);
        press(1, 4'h1);
        repeat (NREGS) @(negedge clk);
        chk("R8 halted", cpu_run, 0);
        for (int i = 0; i < NREGS; i++) chk("R8 copy", ram[DUMP_BASE + 8'(i)], cpu_regs[i*8 +: 8]);
        chk("R8 addr kept", disp[9:0], fdisp(8'h12, 8'h00) & 25'h3FF);

        // R9 single step and wait for completion
        press(1, 4'hE);
        chk("R9 one step", step_cnt, 1);
        chk("R9 not running", cpu_run, 0);
        press(1, 4'h1);
        chk("R9 key held off", disp[9:0], fdisp(8'h12, 8'h00) & 25'h3FF);
        @(negedge clk); cpu_step_done = 1;
        @(negedge clk); cpu_step_done = 0;
        press(1, 4'h1);
        chk("R9 key after done", disp[9:0], fdisp(8'h13, 8'h00) & 25'h3FF);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule